// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

This block is the execution half of a small microcoded processor. A 32-bit shared bus links every storage element: a general register file with an extra slot for the program counter, two operand latches (A and B), an ALU, an instruction register with an immediate extender, and a memory-address register. A microcode sequencer outside the block supplies 17 control lines each cycle. Together they describe one register transfer: one source drives the bus and any set of destinations captures it at the clock edge.

The datapath reports three things back to the sequencer. These are the major opcode of the held instruction, a flag that is high when A holds zero, and the busy line of the memory. The sequencer uses them to dispatch, to take branches and to spin on slow memory accesses. The memory sits outside the block. It is addressed by the memory-address register and takes its write data from the bus.

Top module: `ubus_datapath`

## Requirements
- R1: After reset, A, B, the address register, the instruction register and every register slot (PC included) hold zero. So opcode is 0 and `a_zero` is 1.
- R2: Bus sources are register read (`drv_reg`), ALU (`drv_alu`), memory read data (`drv_mem`) and extended immediate (`drv_imm`). With one enable high the bus equals that source in the same cycle. With none high it is zero. More than one high is illegal and the bus value is then undefined.
- R3: `ld_a`, `ld_b`, `ld_mar` and `ld_ir` each capture the bus value at the clock edge into A, B, the address register and the instruction register. A latch whose load is low keeps its value.
- R4: `reg_sel` picks the slot index: 0 selects IR[25:21], 1 selects IR[20:16], 2 selects IR[15:11], 3 selects slot 32 (the PC) and 4 selects slot 31 (link). Codes 5 to 7 select slot 0. `reg_wr` writes the bus into the selected slot at the edge. The new value is readable from the next cycle.
- R5: Slot 0 always reads zero, and writes to it have no effect.
- R6: `imm_mode` forms the immediate from IR[15:0]. Mode 0 sign-extends it. Mode 1 zero-extends it. Mode 2 sign-extends it and shifts it left by 2. Mode 3 passes the whole instruction register.
- R7: `alu_op` 0 gives A+B, 1 gives A+4, and 2 gives the jump target {A[31:28], B[25:0], 2'b00}.
- R8: `alu_op` 3 decodes the function from IR. When IR[31:26] is 0, IR[5:0] selects the operation: 0x20 add, 0x22 subtract (A-B), 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. Otherwise IR[31:26] selects it: 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor. Any unlisted code gives A+B.
- R9: `mem_addr` is the address register and `mem_wdata` is the bus. `mem_we` follows `mem_wr` (1 write, 0 read), and `mem_req` is high when `drv_mem` or `mem_wr` is high. Memory read data reaches the bus through `drv_mem`, and `busy` repeats the memory busy line in the same cycle.
- R10: `opcode` is IR[31:26] and `a_zero` is high exactly when A is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_reg | input | 1 | Register file drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_mem | input | 1 | Memory read data drives the bus |
| drv_imm | input | 1 | Extended immediate drives the bus |
| ld_a | input | 1 | Load A from the bus |
| ld_b | input | 1 | Load B from the bus |
| ld_mar | input | 1 | Load the memory-address register |
| ld_ir | input | 1 | Load the instruction register |
| reg_wr | input | 1 | Write the bus into the selected slot |
| reg_sel | input | 3 | Slot index source |
| imm_mode | input | 2 | Immediate form |
| alu_op | input | 2 | ALU operation class |
| mem_wr | input | 1 | Memory write (1) or read (0) |
| mem_rdata | input | 32 | Memory read data |
| mem_busy | input | 1 | Memory access still in progress |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| bus_out | output | 32 | Current bus value |
| opcode | output | 6 | Major opcode of the instruction register |
| a_zero | output | 1 | A equals zero |
| busy | output | 1 | Memory busy, passed to the sequencer |

## Verification
The bus, the memory request lines and `busy` depend on the current control word with no register in the path. Each cycle the bench drives the controls just after the falling edge and compares these outputs 1 ns later, before the rising edge that uses them. A latch load, a slot write, `opcode` and `a_zero` take effect at that rising edge, so the bench changes its model only after that edge and checks the effect in the following cycle's compare or read-back. Memory reads settle after a fixed number of busy cycles. The micro-sequences repeat the memory step until `busy` is seen low, and the value kept from that last cycle is the one checked.

// File: rtl/ubus_pkg.sv
package ubus_pkg;

    typedef enum logic [2:0] {
        SEL_RS   = 3'd0,
        SEL_RT   = 3'd1,
        SEL_RD   = 3'd2,
        SEL_PC   = 3'd3,
        SEL_LINK = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        IMM_SEXT     = 2'd0,
        IMM_ZEXT     = 2'd1,
        IMM_SEXT_SH2 = 2'd2,
        IMM_RAW      = 2'd3
    } imm_mode_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_INC4 = 2'd1,
        ALU_JTGT = 2'd2,
        ALU_DEC  = 2'd3
    } alu_op_e;

    // bus source positions in the one-hot enable vector
    localparam int unsigned SRC_REG = 0;
    localparam int unsigned SRC_ALU = 1;
    localparam int unsigned SRC_MEM = 2;
    localparam int unsigned SRC_IMM = 3;
    localparam int unsigned NSRC    = 4;

    // instruction field layout
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned FLD_W   = 5;
    localparam int unsigned RS_LSB  = 21;
    localparam int unsigned RT_LSB  = 16;
    localparam int unsigned RD_LSB  = 11;
    localparam int unsigned IMM_W   = 16;

    // register-form function codes
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // immediate-form major opcodes
    localparam logic [5:0] OP_RFORM = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_XORI  = 6'h0E;

endpackage

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 33,
    parameter int unsigned RIW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RIW-1:0] idx,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data
);
    localparam logic [RIW-1:0] TOP_SLOT = RIW'(NREG - 1);

    logic [NREG-1:0][DW-1:0] slots_d;
    logic [NREG-1:0][DW-1:0] slots_q;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == 0) begin : g_hard_zero
            assign slots_d[g] = '0;
        end else begin : g_writable
            assign slots_d[g] = (wr_en && idx == RIW'(g)) ? wr_data : slots_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    always_comb begin
        if (idx == '0 || idx > TOP_SLOT) begin
            rd_data = '0;
        end else begin
            rd_data = slots_q[idx];
        end
    end

endmodule

// File: rtl/ubus_immext.sv
module ubus_immext
    import ubus_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] ir,
    input  logic [1:0]    mode,
    output logic [DW-1:0] imm
);
    logic [DW-1:0] sext;
    logic [DW-1:0] zext;

    assign sext = {{(DW-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    assign zext = {{(DW-IMM_W){1'b0}}, ir[IMM_W-1:0]};

    always_comb begin
        case (imm_mode_e'(mode))
            IMM_SEXT:     imm = sext;
            IMM_ZEXT:     imm = zext;
            IMM_SEXT_SH2: imm = {sext[DW-3:0], 2'b00};
            default:      imm = ir;
        endcase
    end

endmodule

// File: rtl/ubus_alu.sv
module ubus_alu
    import ubus_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [1:0]       op,
    input  logic [OPC_W-1:0] ir_opc,
    input  logic [5:0]       ir_fn,
    output logic [DW-1:0]    y
);
    localparam int unsigned SEG_W = 4;
    localparam int unsigned OFS_W = DW - SEG_W - 2;

    logic [DW-1:0] sum;
    logic [DW-1:0] diff;
    logic [DW-1:0] lt;
    logic [DW-1:0] decoded;

    assign sum  = a + b;
    assign diff = a - b;
    assign lt   = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};

    always_comb begin
        decoded = sum;
        if (ir_opc == OP_RFORM) begin
            case (ir_fn)
                FN_ADD:  decoded = sum;
                FN_SUB:  decoded = diff;
                FN_AND:  decoded = a & b;
                FN_OR:   decoded = a | b;
                FN_XOR:  decoded = a ^ b;
                FN_SLT:  decoded = lt;
                default: decoded = sum;
            endcase
        end else begin
            case (ir_opc)
                OP_ADDI: decoded = sum;
                OP_SLTI: decoded = lt;
                OP_ANDI: decoded = a & b;
                OP_ORI:  decoded = a | b;
                OP_XORI: decoded = a ^ b;
                default: decoded = sum;
            endcase
        end
    end

    always_comb begin
        case (alu_op_e'(op))
            ALU_ADD:  y = sum;
            ALU_INC4: y = a + DW'(4);
            ALU_JTGT: y = {a[DW-1 -: SEG_W], b[OFS_W-1:0], 2'b00};
            default:  y = decoded;
        endcase
    end

endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
    import ubus_pkg::*;
#(
    parameter int unsigned DW       = 32,
    parameter int unsigned NREG     = 33,
    parameter int unsigned LINK_IDX = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drv_reg,
    input  logic          drv_alu,
    input  logic          drv_mem,
    input  logic          drv_imm,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic          ld_mar,
    input  logic          ld_ir,
    input  logic          reg_wr,
    input  logic [2:0]    reg_sel,
    input  logic [1:0]    imm_mode,
    input  logic [1:0]    alu_op,
    input  logic          mem_wr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] bus_out,
    output logic [5:0]    opcode,
    output logic          a_zero,
    output logic          busy
);
    localparam int unsigned   RIW       = $clog2(NREG);
    localparam logic [RIW-1:0] PC_SLOT  = RIW'(NREG - 1);
    localparam logic [RIW-1:0] LNK_SLOT = RIW'(LINK_IDX);

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] mar;
        logic [DW-1:0] ir;
    } latch_t;

    latch_t          core_d;
    latch_t          core_q;
    logic [RIW-1:0]  rf_idx;
    logic [DW-1:0]   rf_rdata;
    logic [DW-1:0]   alu_y;
    logic [DW-1:0]   imm_val;
    logic [NSRC-1:0] src_en;
    logic [DW-1:0]   src_val [NSRC];
    logic [DW-1:0]   bus;

    // slot index from instruction fields or forced slots
    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_RS:   rf_idx = RIW'(core_q.ir[RS_LSB +: FLD_W]);
            SEL_RT:   rf_idx = RIW'(core_q.ir[RT_LSB +: FLD_W]);
            SEL_RD:   rf_idx = RIW'(core_q.ir[RD_LSB +: FLD_W]);
            SEL_PC:   rf_idx = PC_SLOT;
            SEL_LINK: rf_idx = LNK_SLOT;
            default:  rf_idx = '0;
        endcase
    end

    ubus_regfile #(.DW(DW), .NREG(NREG), .RIW(RIW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (rf_idx),
        .wr_en   (reg_wr),
        .wr_data (bus),
        .rd_data (rf_rdata)
    );

    ubus_immext #(.DW(DW)) u_imm (
        .ir   (core_q.ir),
        .mode (imm_mode),
        .imm  (imm_val)
    );

    ubus_alu #(.DW(DW)) u_alu (
        .a      (core_q.a),
        .b      (core_q.b),
        .op     (alu_op),
        .ir_opc (core_q.ir[DW-1 -: OPC_W]),
        .ir_fn  (core_q.ir[5:0]),
        .y      (alu_y)
    );

    // shared bus: gated sources merged, zero when idle
    always_comb begin
        src_en           = '0;
        src_en[SRC_REG]  = drv_reg;
        src_en[SRC_ALU]  = drv_alu;
        src_en[SRC_MEM]  = drv_mem;
        src_en[SRC_IMM]  = drv_imm;
        src_val[SRC_REG] = rf_rdata;
        src_val[SRC_ALU] = alu_y;
        src_val[SRC_MEM] = mem_rdata;
        src_val[SRC_IMM] = imm_val;
    end

    always_comb begin
        bus = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_en[i]) begin
                bus = bus | src_val[i];
            end
        end
    end

    // next-state of the latches
    always_comb begin
        core_d = core_q;
        if (ld_a) begin
            core_d.a = bus;
        end
        if (ld_b) begin
            core_d.b = bus;
        end
        if (ld_mar) begin
            core_d.mar = bus;
        end
        if (ld_ir) begin
            core_d.ir = bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_req   = drv_mem | mem_wr;
    assign mem_we    = mem_wr;
    assign mem_addr  = core_q.mar;
    assign mem_wdata = bus;
    assign bus_out   = bus;
    assign opcode    = core_q.ir[DW-1 -: OPC_W];
    assign a_zero    = (core_q.a == '0);
    assign busy      = mem_busy;

endmodule

// File: rtl/ubus_datapath_chk.sv
module ubus_datapath_chk #(
    parameter int unsigned DW  = 32,
    parameter int unsigned RIW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic [3:0]     src_en,
    input logic [DW-1:0]  bus,
    input logic [RIW-1:0] rf_idx,
    input logic           ld_a,
    input logic           ld_mar,
    input logic [DW-1:0]  a_q,
    input logic [DW-1:0]  mem_addr,
    input logic [1:0]     alu_sel
);
    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_en) <= 1); // R2

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 4'b0000) |-> (bus == '0)); // R2

    AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 4'b0001 && rf_idx == '0) |-> (bus == '0)); // R5

    AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_a |=> (a_q == $past(bus))); // R3

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a |=> $stable(a_q)); // R3

    AST_MAR_TO_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mar |=> (mem_addr == $past(bus))); // R9

    AST_JUMP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == 4'b0010 && alu_sel == 2'd2) |-> (bus[1:0] == 2'b00)); // R7

endmodule

bind ubus_datapath ubus_datapath_chk #(.DW(DW), .RIW(RIW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en   (src_en),
    .bus      (bus),
    .rf_idx   (rf_idx),
    .ld_a     (ld_a),
    .ld_mar   (ld_mar),
    .a_q      (core_q.a),
    .mem_addr (mem_addr),
    .alu_sel  (alu_op)
);

// File: tb/ubus_datapath_tb.sv
module ubus_datapath_tb;
    localparam int LAT = 2;
    localparam logic [2:0] S_RS = 3'd0, S_RT = 3'd1, S_RD = 3'd2, S_PC = 3'd3, S_LNK = 3'd4;
    localparam logic [1:0] M_SX = 2'd0, M_ZX = 2'd1, M_SH = 2'd2, M_RAW = 2'd3;
    localparam logic [1:0] A_ADD = 2'd0, A_INC = 2'd1, A_JT = 2'd2, A_DEC = 2'd3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic drv_reg, drv_alu, drv_mem, drv_imm, ld_a, ld_b, ld_mar, ld_ir, reg_wr, mem_wr;
    logic [2:0] reg_sel;
    logic [1:0] imm_mode, alu_op;
    logic [31:0] mem_rdata, mem_addr, mem_wdata, bus_out;
    logic mem_busy, mem_req, mem_we, a_zero, busy;
    logic [5:0] opcode;

    ubus_datapath u_dut (
        .clk(clk), .rst_n(rst_n),
        .drv_reg(drv_reg), .drv_alu(drv_alu), .drv_mem(drv_mem), .drv_imm(drv_imm),
        .ld_a(ld_a), .ld_b(ld_b), .ld_mar(ld_mar), .ld_ir(ld_ir),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .imm_mode(imm_mode), .alu_op(alu_op),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_busy(mem_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .bus_out(bus_out), .opcode(opcode), .a_zero(a_zero), .busy(busy)
    );

    // slow memory: busy for LAT cycles of each request
    logic [31:0] mem [0:63];
    int unsigned wcnt;
    always @(posedge clk) begin
        if (!rst_n || !mem_req) wcnt <= 0;
        else if (wcnt != LAT) wcnt <= wcnt + 1;
        if (rst_n && mem_req && mem_we && !mem_busy) mem[mem_addr[7:2]] <= mem_wdata;
    end
    assign mem_busy  = mem_req && (wcnt != LAT);
    assign mem_rdata = mem[mem_addr[7:2]];

    // behavioural reference state
    logic [31:0] m_rf [0:32];
    logic [31:0] m_a, m_b, m_mar, m_ir;
    int n_tests = 0;
    int n_fail  = 0;
    bit busy_seen;
    logic [31:0] last_bus;
    logic last_az;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_idx(input logic [2:0] sel);
        case (sel)
            S_RS:  return int'(m_ir[25:21]);
            S_RT:  return int'(m_ir[20:16]);
            S_RD:  return int'(m_ir[15:11]);
            S_PC:  return 32;
            S_LNK: return 31;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_imm(input logic [1:0] md);
        logic [31:0] s;
        s = {{16{m_ir[15]}}, m_ir[15:0]};
        case (md)
            M_SX: return s;
            M_ZX: return {16'h0, m_ir[15:0]};
            M_SH: return s * 4;
            default: return m_ir;
        endcase
    endfunction

    function automatic logic [31:0] m_alu(input logic [1:0] op);
        int sa, sb;
        sa = $signed(m_a);
        sb = $signed(m_b);
        if (op == A_ADD) return m_a + m_b;
        if (op == A_INC) return m_a + 4;
        if (op == A_JT) return (m_a & 32'hF000_0000) | ((m_b & 32'h03FF_FFFF) << 2);
        if (m_ir[31:26] == 6'h00) begin
            case (m_ir[5:0])
                6'h22: return m_a - m_b;
                6'h24: return m_a & m_b;
                6'h25: return m_a | m_b;
                6'h26: return m_a ^ m_b;
                6'h2A: return (sa < sb) ? 32'd1 : 32'd0;
                default: return m_a + m_b;
            endcase
        end
        case (m_ir[31:26])
            6'h0A: return (sa < sb) ? 32'd1 : 32'd0;
            6'h0C: return m_a & m_b;
            6'h0D: return m_a | m_b;
            6'h0E: return m_a ^ m_b;
            default: return m_a + m_b;
        endcase
    endfunction

    // one micro-step: drive, compare away from the edge, advance the model
    task automatic step(input string tag, input bit dr, input bit da, input bit dm, input bit di,
                        input bit la, input bit lb, input bit lmar, input bit lir, input bit rw,
                        input logic [2:0] sel, input logic [1:0] im, input logic [1:0] op,
                        input bit mw);
        logic [31:0] eb;
        int ix;
        @(negedge clk);
        drv_reg = dr; drv_alu = da; drv_mem = dm; drv_imm = di;
        ld_a = la; ld_b = lb; ld_mar = lmar; ld_ir = lir; reg_wr = rw;
        reg_sel = sel; imm_mode = im; alu_op = op; mem_wr = mw;
        #1;
        ix = m_idx(sel);
        eb = 32'h0;
        if (dr) eb = eb | ((ix == 0 || ix > 32) ? 32'h0 : m_rf[ix]);
        if (da) eb = eb | m_alu(op);
        if (dm) eb = eb | mem[m_mar[7:2]];
        if (di) eb = eb | m_imm(im);
        chk({tag, " bus"}, bus_out, eb);
        chk("R9 mem_addr", mem_addr, m_mar);
        chk("R9 mem_req/we", {30'h0, mem_req, mem_we}, {30'h0, (dm | mw), mw});
        chk("R10 opcode", {26'h0, opcode}, {26'h0, m_ir[31:26]});
        chk("R10 a_zero", {31'h0, a_zero}, {31'h0, (m_a == 32'h0)});
        chk("R9 busy", {31'h0, busy}, {31'h0, mem_busy});
        busy_seen = mem_busy;
        last_bus  = bus_out;
        last_az   = a_zero;
        @(posedge clk);
        if (la)   m_a   = eb;
        if (lb)   m_b   = eb;
        if (lmar) m_mar = eb;
        if (lir)  m_ir  = eb;
        if (rw && ix != 0 && ix <= 32) m_rf[ix] = eb;
    endtask

    task automatic nop();
        step("R2 idle", 0,0,0,0, 0,0,0,0, 0, S_RS, M_SX, A_ADD, 0);
    endtask

    task automatic read_slot(input logic [2:0] sel);
        step("R4 read", 1,0,0,0, 0,0,0,0, 0, sel, M_SX, A_ADD, 0);
    endtask

    task automatic fetch();
        step("R4 MA<-PC", 1,0,0,0, 0,0,1,0, 0, S_PC, M_SX, A_ADD, 0);
        do step("R9 IR<-mem", 0,0,1,0, 0,0,0,1, 0, S_RS, M_SX, A_ADD, 0); while (busy_seen);
        step("R3 A<-PC", 1,0,0,0, 1,0,0,0, 0, S_PC, M_SX, A_ADD, 0);
        step("R7 PC<-A+4", 0,1,0,0, 0,0,0,0, 1, S_PC, M_SX, A_INC, 0);
    endtask

    task automatic load_a_rs();
        step("R4 A<-rs", 1,0,0,0, 1,0,0,0, 0, S_RS, M_SX, A_ADD, 0);
    endtask

    task automatic op_reg();
        load_a_rs();
        step("R4 B<-rt", 1,0,0,0, 0,1,0,0, 0, S_RT, M_SX, A_ADD, 0);
        step("R8 rd<-f(A,B)", 0,1,0,0, 0,0,0,0, 1, S_RD, M_SX, A_DEC, 0);
    endtask

    task automatic op_imm(input logic [1:0] md);
        load_a_rs();
        step("R6 B<-imm", 0,0,0,1, 0,1,0,0, 0, S_RS, md, A_ADD, 0);
        step("R8 rt<-f(A,B)", 0,1,0,0, 0,0,0,0, 1, S_RT, M_SX, A_DEC, 0);
    endtask

    task automatic addr_calc();
        load_a_rs();
        step("R6 B<-sext", 0,0,0,1, 0,1,0,0, 0, S_RS, M_SX, A_ADD, 0);
        step("R7 MA<-A+B", 0,1,0,0, 0,0,1,0, 0, S_RS, M_SX, A_ADD, 0);
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[0]  = enc_i(6'h08, 0, 1, 16'h0005);   // r1 = 5
        mem[1]  = enc_i(6'h0D, 0, 2, 16'h8003);   // r2 = 0x8003
        mem[2]  = enc_i(6'h08, 0, 4, 16'hFFFE);   // r4 = -2
        mem[3]  = enc_r(1, 2, 3, 6'h22);          // r3 = r1 - r2
        mem[4]  = enc_r(4, 1, 5, 6'h2A);          // r5 = r4 < r1
        mem[5]  = enc_i(6'h23, 0, 6, 16'h0040);   // load r6
        mem[6]  = enc_i(6'h2B, 0, 1, 16'h0044);   // store r1
        mem[7]  = {6'h02, 26'd12};                // jump to 0x30
        mem[12] = enc_r(1, 2, 7, 6'h26);          // r7 = r1 ^ r2
        mem[13] = enc_r(1, 1, 0, 6'h20);          // write to r0
        mem[16] = 32'h1234_5678;
        for (int i = 0; i <= 32; i++) m_rf[i] = 32'h0;
        m_a = 0; m_b = 0; m_mar = 0; m_ir = 0;
        rst_n = 1'b0;
        drv_reg = 0; drv_alu = 0; drv_mem = 0; drv_imm = 0;
        ld_a = 0; ld_b = 0; ld_mar = 0; ld_ir = 0; reg_wr = 0; mem_wr = 0;
        reg_sel = 0; imm_mode = 0; alu_op = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 a_zero after reset", {31'h0, a_zero}, 32'h1);
        chk("R1 opcode after reset", {26'h0, opcode}, 32'h0);
        chk("R1 mem_addr after reset", mem_addr, 32'h0);
        chk("R2 idle bus", bus_out, 32'h0);
        read_slot(S_PC);
        chk("R1 PC after reset", last_bus, 32'h0);

        fetch(); op_imm(M_SX);
        read_slot(S_RT); chk("R8 addi result", last_bus, 32'h5);
        fetch(); op_imm(M_ZX);
        read_slot(S_RT); chk("R6 zero-extended ori", last_bus, 32'h0000_8003);
        fetch(); op_imm(M_SX);
        read_slot(S_RT); chk("R6 sign-extended addi", last_bus, 32'hFFFF_FFFE);
        fetch(); op_reg();
        read_slot(S_RD); chk("R8 subtract", last_bus, 32'hFFFF_8002);
        fetch(); op_reg();
        read_slot(S_RD); chk("R8 signed less-than", last_bus, 32'h1);

        fetch(); addr_calc();
        do step("R9 rt<-mem", 0,0,1,0, 0,0,0,0, 1, S_RT, M_SX, A_ADD, 0); while (busy_seen);
        read_slot(S_RT); chk("R9 loaded word", last_bus, 32'h1234_5678);

        fetch(); addr_calc();
        do step("R9 mem<-rt", 1,0,0,0, 0,0,0,0, 0, S_RT, M_SX, A_ADD, 1); while (busy_seen);
        nop();
        chk("R9 stored word", mem[17], 32'h5);

        fetch();
        step("R3 A<-PC", 1,0,0,0, 1,0,0,0, 0, S_PC, M_SX, A_ADD, 0);
        step("R6 B<-IR", 0,0,0,1, 0,1,0,0, 0, S_RS, M_RAW, A_ADD, 0);
        step("R7 PC<-target", 0,1,0,0, 0,0,0,0, 1, S_PC, M_SX, A_JT, 0);
        read_slot(S_PC); chk("R7 jump target", last_bus, 32'h30);

        fetch(); op_reg();
        read_slot(S_RD); chk("R8 xor", last_bus, 32'h8006);
        fetch(); op_reg();
        read_slot(S_RD); chk("R5 slot 0 ignores write", last_bus, 32'h0);
        step("R5 A<-r0", 1,0,0,0, 1,0,0,0, 0, S_RD, M_SX, A_ADD, 0);
        nop(); chk("R10 a_zero on zero A", {31'h0, last_az}, 32'h1);

        step("R3 A<-PC", 1,0,0,0, 1,0,0,0, 0, S_PC, M_SX, A_ADD, 0);
        nop(); chk("R10 a_zero on nonzero A", {31'h0, last_az}, 32'h0);
        step("R6 B<-imm<<2", 0,0,0,1, 0,1,0,0, 0, S_RS, M_SH, A_ADD, 0);
        step("R7 PC<-A+B", 0,1,0,0, 0,0,0,0, 1, S_PC, M_SX, A_ADD, 0);
        read_slot(S_PC); chk("R7 branch target", last_bus, 32'hB8);

        step("R4 link<-imm", 0,0,0,1, 0,0,0,0, 1, S_LNK, M_SX, A_ADD, 0);
        read_slot(S_LNK); chk("R4 link slot", last_bus, 32'h20);
        read_slot(3'd6); chk("R4 spare select reads zero", last_bus, 32'h0);
        step("R3 B held", 0,1,0,0, 0,0,0,0, 0, S_RS, M_SX, A_JT, 0);
        chk("R3 B unchanged", last_bus & 32'h03FF_FFFC, 32'h80 << 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule